// File: doc/BRIEF.md
# Removal-Priority Output Scheduler for a Buffered Crossbar

This block arbitrates one output column of an N-port crossbar that keeps a small cell buffer at every crosspoint. In every clock it looks at which crosspoint buffers of its column hold a cell, and at a vector of removal requests raised by the input-side schedulers. It then picks one buffer whose cell goes to the output link. A removal request takes precedence over ordinary service. When no honoured request is present, the block serves the occupied buffers in round-robin order. Both kinds of choice search from a single rotating priority pointer. After each choice the pointer advances to the position just past the winner.

The choice is registered, so it appears on the outputs one clock after the inputs are sampled. One clock after that, a single-cycle delivery notice goes back to the winning input. The input side uses that notice to account for the space freed in its crosspoint buffer. The buffers themselves and the link serialisation sit outside this block.

Top module: `rmv_out_sched`

## Requirements
- R1: After reset, `sel_valid_o`, `sel_o` and `notify_o` are all zero and the priority pointer is at position 0, so the first choice searches upward from index 0.
- R2: When at least one index has both `rmv_req_i` and `occ_i` set, the chosen index is the first such index found by searching upward from the pointer and wrapping from N-1 to 0.
- R3: When no index has both bits set, the chosen index is the first index with `occ_i` set, found by searching upward from the pointer with wrap.
- R4: A removal request on an index whose `occ_i` bit is 0 is ignored. It neither selects that index nor suppresses round-robin service of the occupied buffers.
- R5: After a choice of index k, the pointer becomes k+1, or 0 when k is N-1.
- R6: When `occ_i` is all zero, `sel_valid_o` is 0, `sel_o` is zero and the pointer keeps its value.
- R7: `notify_o` is one-hot on the chosen index for exactly the one clock that follows the clock in which `sel_o` showed that choice. It is zero after a cycle with no choice.
- R8: Outputs are registered. Inputs sampled at clock edge t drive `sel_o` and `sel_valid_o` after edge t. Bit k of `sel_o` means index k, and `sel_o` is one-hot exactly when `sel_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| occ_i | input | N_PORTS | Bit k set: crosspoint buffer from input k holds a cell |
| rmv_req_i | input | N_PORTS | Bit k set: input k asks for its buffered cell to be removed |
| sel_o | output | N_PORTS | One-hot chosen crosspoint buffer |
| sel_valid_o | output | 1 | A choice was made this cycle |
| notify_o | output | N_PORTS | One-cycle, one-hot delivery notice to the input served on the previous cycle |

## Verification
Two things can compete in the same clock. One is a removal request on an occupied buffer that lies far from the pointer. The other is an occupied, unrequested buffer that the round-robin search would reach first. The bench builds this case on purpose: it places the pointer just below a plain occupied buffer and raises a request several positions further on. It then checks that the requested index wins and that the pointer jumps past it. The delivery notice for one choice also falls in the same cycle as the next choice. The bench runs back-to-back choices and judges each notice against the previous expected selection, not the current one.

// File: rtl/rmv_pkg.sv
// Package: shared types for the removal-priority output scheduler.
// Assumes nothing beyond IEEE 1800-2017.
package rmv_pkg;

    // Which search produced the choice in a cycle.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_REMOVE = 2'd1,
        SRC_RR     = 2'd2
    } pick_src_e;

endpackage

// File: rtl/rmv_rr_pick.sv
// Module: rmv_rr_pick
// Purely combinational search for the first set bit of req_i, starting at
// index ptr_i and wrapping from NP-1 to 0. Gives a one-hot grant, its
// binary index and a found flag.
// Assumes NP >= 2 and ptr_i < NP.
module rmv_rr_pick #(
    parameter int NP = 8,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [NP-1:0] req_i,
    input  logic [IW-1:0] ptr_i,
    output logic [NP-1:0] gnt_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    // Walk the NP positions in rotated order and keep the first hit.
    always_comb begin
        logic [IW:0] pos;
        gnt_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        for (int k = 0; k < NP; k++) begin
            pos = {1'b0, ptr_i} + (IW+1)'(k);
            if (pos >= (IW+1)'(NP)) pos = pos - (IW+1)'(NP);
            if (!any_o && req_i[pos[IW-1:0]]) begin
                any_o = 1'b1;
                idx_o = pos[IW-1:0];
                gnt_o[pos[IW-1:0]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rmv_ptr_reg.sv
// Module: rmv_ptr_reg
// Holds the rotating priority pointer. On a taken choice it loads the
// position one past the winner, wrapping to 0. Otherwise it holds.
// Assumes win_idx_i < NP whenever take_i is high.
module rmv_ptr_reg #(
    parameter int NP = 8,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [IW-1:0] win_idx_i,
    output logic [IW-1:0] ptr_o
);

    // Pointer update: reset to 0, advance past the winner on a choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else if (take_i) begin
            if (win_idx_i == IW'(NP-1)) ptr_o <= '0;
            else                         ptr_o <= win_idx_i + IW'(1);
        end
    end

endmodule

// File: rtl/rmv_out_sched.sv
// Module: rmv_out_sched (top)
// Per-output scheduler of a buffered crossbar. An occupied buffer with a
// removal request wins over plain round-robin service. Both searches share
// one pointer. The choice is registered. A one-cycle delivery notice
// follows it by one clock.
// Assumes occ_i and rmv_req_i are synchronous to clk.
module rmv_out_sched
    import rmv_pkg::*;
#(
    parameter int N_PORTS = 8,
    localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] occ_i,
    input  logic [N_PORTS-1:0] rmv_req_i,
    output logic [N_PORTS-1:0] sel_o,
    output logic               sel_valid_o,
    output logic [N_PORTS-1:0] notify_o
);

    logic [IW-1:0]      ptr;
    logic [N_PORTS-1:0] honoured;
    logic [N_PORTS-1:0] gnt_rm, gnt_rr, gnt;
    logic [IW-1:0]      idx_rm, idx_rr, idx;
    logic               any_rm, any_rr;
    pick_src_e          src;

    // Keep only removal requests whose buffer actually holds a cell.
    always_comb honoured = rmv_req_i & occ_i;

    rmv_rr_pick #(.NP(N_PORTS)) i_pick_rm (
        .req_i(honoured), .ptr_i(ptr),
        .gnt_o(gnt_rm), .idx_o(idx_rm), .any_o(any_rm)
    );

    rmv_rr_pick #(.NP(N_PORTS)) i_pick_rr (
        .req_i(occ_i), .ptr_i(ptr),
        .gnt_o(gnt_rr), .idx_o(idx_rr), .any_o(any_rr)
    );

    // Choose the source: removal search first, then plain round-robin.
    always_comb begin
        if (any_rm)      src = SRC_REMOVE;
        else if (any_rr) src = SRC_RR;
        else             src = SRC_NONE;
        unique case (src)
            SRC_REMOVE: begin gnt = gnt_rm; idx = idx_rm; end
            SRC_RR:     begin gnt = gnt_rr; idx = idx_rr; end
            default:    begin gnt = '0;     idx = '0;     end
        endcase
    end

    rmv_ptr_reg #(.NP(N_PORTS)) i_ptr (
        .clk(clk), .rst_n(rst_n),
        .take_i(src != SRC_NONE), .win_idx_i(idx), .ptr_o(ptr)
    );

    // Register the choice and, one clock later, the delivery notice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o       <= '0;
            sel_valid_o <= 1'b0;
            notify_o    <= '0;
        end else begin
            sel_o       <= gnt;
            sel_valid_o <= (src != SRC_NONE);
            notify_o    <= sel_valid_o ? sel_o : '0;
        end
    end

    // R8: a valid choice is exactly one bit, no choice is all zero.
    a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o ? ($countones(sel_o) == 1) : (sel_o == '0));

    // R2 / R4: an honoured request last cycle means the winner was one of them.
    a_r2_request_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rmv_req_i & occ_i)) |=> (sel_valid_o && ((sel_o & $past(rmv_req_i & occ_i)) != '0)));

    // R3: any choice names a buffer that was occupied when sampled.
    a_r3_sel_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        (|occ_i) |=> (sel_valid_o && ((sel_o & $past(occ_i)) != '0)));

    // R6: an empty column gives no choice and leaves the pointer alone.
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_i == '0) |=> (!sel_valid_o && $stable(ptr)));

    // R7: the notice repeats the previous selection for one cycle.
    a_r7_notify_follow: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |=> (notify_o == $past(sel_o)));

    // R7: no notice after a cycle without a choice.
    a_r7_notify_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_o |=> (notify_o == '0));

endmodule

// File: tb/test_rmv_out_sched.sv
// Scoreboard bench: the driver applies inputs and queues the expected choice
// from a reference model of the requirements. The monitor pops and compares
// after every clock edge.
module test_rmv_out_sched;

    localparam int NP = 8;

    typedef struct {
        logic          v;
        logic [NP-1:0] s;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] occ = '0;
    logic [NP-1:0] rq = '0;
    logic [NP-1:0] sel_o, notify_o;
    logic          sel_valid_o;

    int   checks = 0;
    int   errors = 0;
    int   mptr = 0;
    bit   done = 1'b0;
    exp_t q[$];
    exp_t prev = '{v: 1'b0, s: '0};
    bit   armed = 1'b0;

    always #5 clk = ~clk;

    rmv_out_sched #(.N_PORTS(NP)) i_rmv_out_sched (
        .clk(clk), .rst_n(rst_n), .occ_i(occ), .rmv_req_i(rq),
        .sel_o(sel_o), .sel_valid_o(sel_valid_o), .notify_o(notify_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one input pattern and queue the expected result.
    task automatic step(input logic [NP-1:0] o, input logic [NP-1:0] r);
        exp_t e;
        logic [NP-1:0] h;
        int win;
        @(negedge clk);
        occ = o;
        rq  = r;
        h   = r & o;
        win = -1;
        for (int k = 0; k < NP; k++) begin
            int p = (mptr + k) % NP;
            if (win < 0 && h[p]) win = p;
        end
        for (int k = 0; k < NP; k++) begin
            int p = (mptr + k) % NP;
            if (win < 0 && h == '0 && o[p]) win = p;
        end
        e.v = (win >= 0);
        e.s = '0;
        if (win >= 0) begin
            e.s[win] = 1'b1;
            mptr = (win + 1) % NP;
        end
        q.push_back(e);
    endtask

    // Monitor: compare the registered outputs just after each edge.
    always @(posedge clk) begin
        #2;
        if (armed && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check("R8 valid (R2/R3/R4/R6)", 32'(sel_valid_o), 32'(e.v));
            check("R2/R3/R5 sel", 32'(sel_o), 32'(e.s));
            check("R7 notify", 32'(notify_o), prev.v ? 32'(prev.s) : 32'd0);
            prev = e;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset (inputs are zero).
        check("R1 valid", 32'(sel_valid_o), 0);
        check("R1 sel", 32'(sel_o), 0);
        check("R1 notify", 32'(notify_o), 0);
        armed = 1'b1;
        // R1 / R3: first choice with everything occupied is index 0.
        step('1, '0);
        // R3 / R5: round-robin continues 1, 2, ...
        step('1, '0);
        step('1, '0);
        // R2: pointer at 3, plain occupied index 3, request on index 6 wins.
        step(8'b0100_1000, 8'b0100_0000);
        // R5: pointer now 7; wrap to 0 via round-robin.
        step(8'b0000_0011, '0);
        // R4: request on an empty buffer ignored, round-robin serves index 1.
        step(8'b0000_0010, 8'b1000_0000);
        // R6: empty column, requests present, nothing chosen, pointer held.
        step('0, '1);
        step('0, '0);
        // R5 after idle: pointer still 2, serves index 2 before 0.
        step(8'b0000_0101, '0);
        // R2 wrap: pointer 3, request only at index 1 (and 0 empty).
        step(8'b1000_0010, 8'b0000_0011);
        // R2: several requests, nearest from pointer wins.
        step('1, 8'b1010_0100);
        step('1, 8'b1010_0100);
        step('1, 8'b1010_0100);
        // R5 wrap at N-1 then round-robin from 0.
        step(8'b1000_0000, 8'b1000_0000);
        step('1, '0);
        // Mixed pseudo-random traffic (R2/R3/R4/R6/R7).
        for (int n = 0; n < 300; n++) begin
            logic [NP-1:0] o, r;
            o = NP'($urandom);
            r = NP'($urandom) & NP'($urandom);
            if (n % 17 == 0) o = '0;
            step(o, r);
        end
        step('0, '0);
        step('0, '0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule